// File: doc/BRIEF.md
# Store Queue with Associative Read Forwarding

This block sits between a write-through cache and main memory. It accepts processor stores (an address and a data word) into a small circular queue. The store is complete as soon as the queue takes it, so the processor never waits for memory on a write. The queue offers its oldest entry to memory through a valid/ready handshake. It retires one entry each time memory accepts it, in the order the stores came in.

Memory can lag behind the queue, so a read to an address that still has a store waiting would otherwise fetch stale data. For this reason every read address is compared against all occupied entries in the same cycle. If any entry matches, the block raises a hit flag and returns the data of the youngest matching store. The cache then uses that data instead of going to memory. The depth is a parameter. The default of four suits write-through use, and a depth of one serves as the single-entry victim slot behind a write-back cache.

Top module: `store_queue`

## Requirements
- R1: After reset the queue holds nothing: `empty`=1, `full`=0, `mem_valid`=0, `st_ready`=1 and `rd_hit`=0. A reset given while entries are held discards all of them.
- R2: `st_ready` is low and `full` is high exactly when DEPTH entries are held. Otherwise `st_ready` is high and `full` is low.
- R3: `mem_valid` is high exactly when at least one entry is held. `mem_addr`/`mem_data` show the oldest held entry. Each cycle with `mem_valid` and `mem_ready` both high removes that entry, so entries leave in arrival order, one per handshake.
- R4: A store offered while `st_ready` is low is ignored and adds no entry.
- R5: A store accepted in the same cycle as a drain leaves the number of held entries unchanged.
- R6: In the same cycle, `rd_hit` is 1 when `rd_addr` equals the address of any held entry, and `rd_data` is then that entry's data. The entry being drained in that cycle still counts. A store presented in the same cycle does not count.
- R7: When several held entries match `rd_addr`, `rd_data` is the data of the most recently accepted one.
- R8: When no held entry matches, `rd_hit` is 0 and `rd_data` is all zeros.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` hold their values and `mem_valid` stays high.
- R10: With DEPTH=1 the block holds one store, reports full, forwards it on a read, and drains it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Queue can accept a store |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_addr | output | AW | Address of oldest entry |
| mem_data | output | DW | Data of oldest entry |
| mem_ready | input | 1 | Memory accepts the offered entry |
| rd_addr | input | AW | Read lookup address |
| rd_hit | output | 1 | Read address matches a held entry |
| rd_data | output | DW | Data of youngest matching entry, zero on miss |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entry held |

## Verification
The hardest situation to reach is a read that matches several held entries after the write and read pointers have wrapped. In that case the youngest entry is not the one at the highest slot index. The stimulus narrows store and read addresses to four values, so repeated addresses pile up. It also holds memory ready low for random stretches, so the queue fills, wraps and partly drains many times. A reference queue in the bench computes the youngest match on every cycle. Directed sequences cover four stores to one address, an offer made while full, a reset with entries held, and the single-entry configuration.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // pointer width for a ring of the given depth, never below one bit
  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // counter width able to hold 0..depth
  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = count;
    if (push && !pop)      cnt_nxt = count + 1'b1;
    else if (pop && !push) cnt_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= cnt_nxt;
      full  <= (cnt_nxt == CAP);
      empty <= (cnt_nxt == '0);
    end
  end
endmodule

// File: rtl/sq_entry_array.sv
module sq_entry_array #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PW    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [PW-1:0]             wr_ptr,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      pop,
  input  logic [PW-1:0]             rd_ptr,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr,
  output logic [DEPTH-1:0][DW-1:0]  ent_data,
  output logic [DEPTH-1:0]          ent_vld
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PW-1:0] IDX = PW'(g);

    // payload registers carry no reset; only the valid bit is cleared
    always_ff @(posedge clk) begin
      if (push && wr_ptr == IDX) begin
        ent_addr[g] <= wr_addr;
        ent_data[g] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                         ent_vld[g] <= 1'b0;
      else if (push && wr_ptr == IDX)  ent_vld[g] <= 1'b1;
      else if (pop && rd_ptr == IDX)   ent_vld[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/sq_lookup.sv
module sq_lookup #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PW    = 2
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [DEPTH-1:0]         ent_vld,
  input  logic [PW-1:0]            head,
  input  logic [AW-1:0]            key,
  output logic                     hit,
  output logic [DW-1:0]            data
);
  logic [DEPTH-1:0] match;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      match[i] = ent_vld[i] && (ent_addr[i] == key);
  end

  // walk from oldest (head) to youngest; the last match found wins
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(head) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (match[idx]) begin
        hit  = 1'b1;
        data = ent_data[idx];
      end
    end
  end
endmodule

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);
  localparam int PW = sq_pkg::ptr_width(DEPTH);
  localparam int CW = sq_pkg::cnt_width(DEPTH);

  logic [PW-1:0]            wr_ptr, rd_ptr;
  logic [CW-1:0]            count;
  logic                     push, pop;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [DEPTH-1:0]         ent_vld;

  assign st_ready  = !full;
  assign mem_valid = !empty;
  assign push      = st_valid && !full;
  assign pop       = !empty && mem_ready;

  sq_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
    .full(full), .empty(empty)
  );

  sq_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_array (
    .clk(clk), .rst(rst), .push(push), .wr_ptr(wr_ptr),
    .wr_addr(st_addr), .wr_data(st_data), .pop(pop), .rd_ptr(rd_ptr),
    .ent_addr(ent_addr), .ent_data(ent_data), .ent_vld(ent_vld)
  );

  sq_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_lookup (
    .ent_addr(ent_addr), .ent_data(ent_data), .ent_vld(ent_vld),
    .head(rd_ptr), .key(rd_addr), .hit(rd_hit), .data(rd_data)
  );

  assign mem_addr = ent_addr[rd_ptr];
  assign mem_data = ent_data[rd_ptr];
endmodule

// File: rtl/store_queue_chk.sv
module store_queue_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             st_valid,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_data,
  input logic             rd_hit,
  input logic [DW-1:0]    rd_data,
  input logic             full,
  input logic             empty,
  input logic [CW-1:0]    count,
  input logic [DEPTH-1:0] ent_vld
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !full && ent_vld == '0)); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R2
  AST_VALID_TRACKS_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(ent_vld) == int'(count)); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && st_valid && !mem_ready) |=> full); // R4
  AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> !empty); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |-> rd_data == '0); // R8
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R9
endmodule

bind store_queue store_queue_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .rd_hit(rd_hit), .rd_data(rd_data), .full(full), .empty(empty),
  .count(count), .ent_vld(ent_vld)
);

// File: tb/store_queue_test.sv
`timescale 1ns/1ps
module store_queue_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       st_valid = 0, mem_ready = 0;
  logic [3:0] st_addr = 0, rd_addr = 0;
  logic [7:0] st_data = 0;
  logic       st_ready, mem_valid, rd_hit, full, empty;
  logic [3:0] mem_addr;
  logic [7:0] mem_data, rd_data;

  logic       b_st_valid = 0, b_mem_ready = 0;
  logic [3:0] b_st_addr = 0, b_rd_addr = 0;
  logic [7:0] b_st_data = 0;
  logic       b_st_ready, b_mem_valid, b_rd_hit, b_full, b_empty;
  logic [3:0] b_mem_addr;
  logic [7:0] b_mem_data, b_rd_data;

  store_queue #(.DEPTH(4), .AW(4), .DW(8)) uut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_ready(st_ready), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
    .full(full), .empty(empty));

  store_queue #(.DEPTH(1), .AW(4), .DW(8)) uut1 (
    .clk(clk), .rst(rst), .st_valid(b_st_valid), .st_addr(b_st_addr), .st_data(b_st_data),
    .st_ready(b_st_ready), .mem_valid(b_mem_valid), .mem_addr(b_mem_addr), .mem_data(b_mem_data),
    .mem_ready(b_mem_ready), .rd_addr(b_rd_addr), .rd_hit(b_rd_hit), .rd_data(b_rd_data),
    .full(b_full), .empty(b_empty));

  int errs = 0, checks = 0;
  logic [3:0] qa[$];
  logic [7:0] qd[$];
  bit prev_both = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle on the depth-4 unit: drive at negedge, compare, update model at posedge
  task automatic cyc(input bit sv, input logic [3:0] sa, input logic [7:0] sd,
                     input bit mr, input logic [3:0] ra);
    int n, hits;
    bit eh, do_push, do_pop;
    logic [7:0] ed;
    string ft, rt;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; mem_ready = mr; rd_addr = ra;
    #1;
    n = qa.size();
    ft = prev_both ? "R5" : "R2";
    chk(st_ready == (n < 4), ft, st_ready, n < 4);
    chk(full == (n == 4), ft, full, n == 4);
    chk(empty == (n == 0), "R3", empty, n == 0);
    chk(mem_valid == (n > 0), "R3", mem_valid, n > 0);
    if (n > 0) begin
      chk(mem_addr == qa[0], "R3", mem_addr, qa[0]);
      chk(mem_data == qd[0], "R3", mem_data, qd[0]);
    end
    eh = 0; ed = '0; hits = 0;
    for (int i = 0; i < n; i++)
      if (qa[i] == ra) begin eh = 1; ed = qd[i]; hits++; end
    rt = (hits > 1) ? "R7" : (eh ? "R6" : "R8");
    chk(rd_hit == eh, rt, rd_hit, eh);
    chk(rd_data == ed, rt, rd_data, ed);
    do_push = sv && (n < 4);
    do_pop  = (n > 0) && mr;
    @(posedge clk);
    if (do_pop)  begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (do_push) begin qa.push_back(sa); qd.push_back(sd); end
    prev_both = do_push && do_pop;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state on both configurations
    chk(empty == 1, "R1", empty, 1);
    chk(full == 0, "R1", full, 0);
    chk(mem_valid == 0, "R1", mem_valid, 0);
    chk(st_ready == 1, "R1", st_ready, 1);
    chk(rd_hit == 0, "R1", rd_hit, 0);
    chk(b_empty == 1 && b_st_ready == 1, "R1", b_empty, 1);

    // R7: four stores to one address, youngest data forwarded
    for (int i = 0; i < 4; i++) cyc(1, 4'h9, 8'(8'h10 + i), 0, 4'h9);
    // R4: offers while full, then drain four and expect empty
    for (int i = 0; i < 3; i++) cyc(1, 4'hE, 8'hEE, 0, 4'hE);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 4'h9);
    @(negedge clk); mem_ready = 0; #1;
    chk(empty == 1, "R4", empty, 1);

    // random sweep over a narrow address space
    for (int c = 0; c < 4000; c++)
      cyc(($urandom % 10) < 7, 4'($urandom % 4), 8'($urandom),
          ($urandom % 10) < 4, 4'($urandom % 4));

    // R1: reset with entries held
    for (int i = 0; i < 2; i++) cyc(1, 4'h3, 8'hA0, 0, 4'h3);
    @(negedge clk); st_valid = 0; rst = 1;
    @(posedge clk); @(negedge clk); rst = 0; rd_addr = 4'h3; #1;
    chk(empty == 1 && mem_valid == 0, "R1", empty, 1);
    chk(rd_hit == 0, "R1", rd_hit, 0);
    qa.delete(); qd.delete(); prev_both = 0;

    // R10: single-entry configuration
    @(negedge clk);
    b_st_valid = 1; b_st_addr = 4'h5; b_st_data = 8'h33; #1;
    chk(b_st_ready == 1, "R10", b_st_ready, 1);
    @(negedge clk);
    b_st_valid = 0; b_rd_addr = 4'h5; #1;
    chk(b_full == 1 && b_st_ready == 0, "R10", b_full, 1);
    chk(b_rd_hit == 1, "R10", b_rd_hit, 1);
    chk(b_rd_data == 8'h33, "R10", b_rd_data, 8'h33);
    chk(b_mem_valid == 1 && b_mem_addr == 4'h5, "R10", b_mem_addr, 5);
    b_st_valid = 1; b_st_addr = 4'h6; b_mem_ready = 1;
    @(negedge clk);
    b_st_valid = 0; b_mem_ready = 0; #1;
    chk(b_empty == 1, "R10", b_empty, 1);

    summary();
    $finish;
  end
endmodule